// File: doc/BRIEF.md
# Coarse-Fine Interpolated Pulse-Width Modulator Core

This block produces one pulse-width modulated output per period of a slow external start request. It runs in a fast clock domain. Each request is first brought into that domain through a flip-flop synchronizer. The synchronized start loads a presettable down-counter with the coarse width, so the coarse width is counted in whole clock periods.

When the counter runs out, the block sends a one-cycle trigger to an external programmable delay element and presents the fine-width code to it. The delay element answers with a returned edge, and that edge clears the output flip-flop. The flip-flop is set by the same start, but only after it has passed through a short shift register. A two-bit offset chooses which tap of that register is used. Choosing the tap cancels the fixed latency of the delay element and of the I/O path, so a coarse value of zero gives a width close to zero.

The output drives four bridge legs. In single-ended mode only leg A switches. In bridge mode one diagonal pair of the H-bridge follows the pulse, and the polarity bit chooses which pair.

Top module: `fine_pwm_ctrl`

## Requirements
- R1: A rising edge of `start_req` starts exactly one cycle, at the third clock edge after the request is first sampled, even when the request stays high for several clocks.
- R2: The coarse counter is loaded at the start edge. `dly_trig` goes high for exactly one clock, 1 + `coarse_width` clocks after the start edge.
- R3: From the start edge on, `fine_code` holds the `fine_width` value captured at that edge.
- R4: The internal PWM flip-flop is set S clocks after the start edge, with S = 1, 3, 5, 7 for `offset_sel` = 0, 1, 2, 3. The driven leg rises one clock after the flip-flop.
- R5: A rising edge on `dly_ret`, sampled at a clock edge, clears the PWM flip-flop at that edge. If it coincides with the set, the clear wins and the width is zero.
- R6: A returned edge that arrives while the PWM flip-flop is clear has no effect on any output.
- R7: A start that arrives while the pulse is still high clears the flip-flop at the start edge. The pending coarse count is discarded and reloaded.
- R8: Coarse, fine, offset, mode and polarity are captured only at the start edge. A write made later in the period takes effect in the next period.
- R9: The legs are registered. When `mode_bipolar` = 0, only `drv_a` follows the pulse. When `mode_bipolar` = 1 and `polarity` = 0, `drv_a` and `drv_d` follow it. When `mode_bipolar` = 1 and `polarity` = 1, `drv_b` and `drv_c` follow it. Every leg that is not selected stays low.
- R10: A synchronous active-high `rst` drives every leg, `dly_trig` and `fine_code` low and stops the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast logic clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Asynchronous periodic start request |
| coarse_width | input | 13 | Coarse width, in clock periods |
| fine_width | input | 8 | Fine code for the delay element |
| offset_sel | input | 2 | Selects the set-delay tap |
| mode_bipolar | input | 1 | 0 single-ended, 1 H-bridge |
| polarity | input | 1 | Selects the bridge diagonal |
| dly_ret | input | 1 | Returned edge from the delay element |
| dly_trig | output | 1 | Trigger to the delay element |
| fine_code | output | 8 | Captured fine code |
| drv_a | output | 1 | Bridge leg A |
| drv_b | output | 1 | Bridge leg B |
| drv_c | output | 1 | Bridge leg C |
| drv_d | output | 1 | Bridge leg D |

## Verification
A behavioural delay stub answers each trigger after a latency set by the fine code. This makes the expected width exactly coarse + latency + 2 − S. The bench drives that width to one and to zero, where a wrong priority between set and clear would leave the pulse stuck high. It also drives the largest coarse value, where an off-by-one counter would shift the trigger. A register write in mid-period must not change the running pulse, or the legs would show the new mode too early. A start that arrives during an active pulse must cut it, or the gap before the next pulse disappears. A stray returned edge while the output is idle must do nothing, and a reset during a pulse must silence every leg and leave no late trigger behind.

// File: rtl/fine_pwm_pkg.sv
package fine_pwm_pkg;
  typedef enum logic {
    DRV_SINGLE = 1'b0,
    DRV_BRIDGE = 1'b1
  } drv_mode_e;
endpackage

// File: rtl/fpwm_sync.sv
module fpwm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise_p
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      last  <= chain[STAGES-1];
    end
  end

  assign rise_p = chain[STAGES-1] & ~last;
endmodule

// File: rtl/fpwm_coarse.sv
module fpwm_coarse #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] value,
  output logic         trig
);
  logic [W-1:0] cnt;
  logic         run;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      run  <= 1'b0;
      trig <= 1'b0;
    end else if (load) begin
      cnt  <= value;
      run  <= 1'b1;
      trig <= 1'b0;
    end else if (run) begin
      if (cnt == '0) begin
        trig <= 1'b1;
        run  <= 1'b0;
      end else begin
        cnt  <= cnt - 1'b1;
        trig <= 1'b0;
      end
    end else begin
      trig <= 1'b0;
    end
  end
endmodule

// File: rtl/fpwm_setdly.sv
module fpwm_setdly #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_p,
  input  logic [SEL_W-1:0] sel,
  output logic             set_p
);
  localparam int NTAP  = 1 << SEL_W;
  localparam int DEPTH = 2 * NTAP - 1;

  logic [DEPTH-1:0] sreg;
  logic [NTAP-1:0]  taps;

  always_ff @(posedge clk) begin
    if (rst) sreg <= '0;
    else     sreg <= {sreg[DEPTH-2:0], start_p};
  end

  for (genvar j = 0; j < NTAP; j++) begin : g_tap
    assign taps[j] = sreg[2*j];
  end

  assign set_p = taps[sel];
endmodule

// File: rtl/fpwm_bridge.sv
module fpwm_bridge
  import fine_pwm_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      pwm,
  input  drv_mode_e mode,
  input  logic      pol,
  output logic      leg_a,
  output logic      leg_b,
  output logic      leg_c,
  output logic      leg_d
);
  always_ff @(posedge clk) begin
    if (rst) begin
      leg_a <= 1'b0;
      leg_b <= 1'b0;
      leg_c <= 1'b0;
      leg_d <= 1'b0;
    end else begin
      leg_a <= 1'b0;
      leg_b <= 1'b0;
      leg_c <= 1'b0;
      leg_d <= 1'b0;
      if (mode == DRV_SINGLE) begin
        leg_a <= pwm;
      end else if (!pol) begin
        leg_a <= pwm;
        leg_d <= pwm;
      end else begin
        leg_b <= pwm;
        leg_c <= pwm;
      end
    end
  end
endmodule

// File: rtl/fine_pwm_ctrl.sv
module fine_pwm_ctrl
  import fine_pwm_pkg::*;
#(
  parameter int COARSE_W    = 13,
  parameter int FINE_W      = 8,
  parameter int OFFSET_W    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_req,
  input  logic [COARSE_W-1:0] coarse_width,
  input  logic [FINE_W-1:0]   fine_width,
  input  logic [OFFSET_W-1:0] offset_sel,
  input  logic                mode_bipolar,
  input  logic                polarity,
  input  logic                dly_ret,
  output logic                dly_trig,
  output logic [FINE_W-1:0]   fine_code,
  output logic                drv_a,
  output logic                drv_b,
  output logic                drv_c,
  output logic                drv_d
);
  logic                start_p;
  logic                set_p;
  logic                ret_q;
  logic                ret_rise;
  logic                pwm_q;
  logic [FINE_W-1:0]   fine_q;
  logic [OFFSET_W-1:0] off_q;
  drv_mode_e           mode_q;
  logic                pol_q;

  fpwm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(start_req), .rise_p(start_p)
  );

  // Shadow registers: loaded only when a period begins.
  always_ff @(posedge clk) begin
    if (rst) begin
      fine_q <= '0;
      off_q  <= '0;
      mode_q <= DRV_SINGLE;
      pol_q  <= 1'b0;
    end else if (start_p) begin
      fine_q <= fine_width;
      off_q  <= offset_sel;
      mode_q <= drv_mode_e'(mode_bipolar);
      pol_q  <= polarity;
    end
  end

  assign fine_code = fine_q;

  fpwm_coarse #(.W(COARSE_W)) u_coarse (
    .clk(clk), .rst(rst), .load(start_p), .value(coarse_width), .trig(dly_trig)
  );

  fpwm_setdly #(.SEL_W(OFFSET_W)) u_setdly (
    .clk(clk), .rst(rst), .start_p(start_p), .sel(off_q), .set_p(set_p)
  );

  always_ff @(posedge clk) begin
    if (rst) ret_q <= 1'b0;
    else     ret_q <= dly_ret;
  end

  assign ret_rise = dly_ret & ~ret_q;

  // Priority: new start, then returned edge, then delayed set.
  always_ff @(posedge clk) begin
    if (rst)           pwm_q <= 1'b0;
    else if (start_p)  pwm_q <= 1'b0;
    else if (ret_rise) pwm_q <= 1'b0;
    else if (set_p)    pwm_q <= 1'b1;
  end

  fpwm_bridge u_bridge (
    .clk(clk), .rst(rst), .pwm(pwm_q), .mode(mode_q), .pol(pol_q),
    .leg_a(drv_a), .leg_b(drv_b), .leg_c(drv_c), .leg_d(drv_d)
  );
endmodule

// File: rtl/fine_pwm_ctrl_chk.sv
module fine_pwm_ctrl_chk
  import fine_pwm_pkg::*;
(
  input logic      clk,
  input logic      rst,
  input logic      start_p,
  input logic      set_p,
  input logic      ret_rise,
  input logic      pwm,
  input logic      trig,
  input drv_mode_e mode,
  input logic      pol,
  input logic      a,
  input logic      b,
  input logic      c,
  input logic      d
);
  logic rst_q;

  always_ff @(posedge clk) rst_q <= rst;

  p_trig_single_r2: assert property (@(posedge clk) disable iff (rst)
    trig |=> !trig);

  p_set_after_tap_r4: assert property (@(posedge clk) disable iff (rst)
    (set_p && !ret_rise && !start_p) |=> pwm);

  p_ret_clears_r5: assert property (@(posedge clk) disable iff (rst)
    (ret_rise && !start_p) |=> !pwm);

  p_start_cuts_r7: assert property (@(posedge clk) disable iff (rst)
    start_p |=> !pwm);

  p_single_leg_r9: assert property (@(posedge clk) disable iff (rst)
    (mode == DRV_SINGLE) |=> !(b || c || d));

  p_diag_ad_r9: assert property (@(posedge clk) disable iff (rst)
    (mode == DRV_BRIDGE && !pol) |=> !(b || c));

  p_diag_bc_r9: assert property (@(posedge clk) disable iff (rst)
    (mode == DRV_BRIDGE && pol) |=> !(a || d));

  always @(negedge clk) begin
    if (rst_q) begin
      p_reset_quiet_r10: assert (!(a || b || c || d || trig));
    end
  end
endmodule

bind fine_pwm_ctrl fine_pwm_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .start_p(start_p), .set_p(set_p),
  .ret_rise(ret_rise), .pwm(pwm_q), .trig(dly_trig), .mode(mode_q),
  .pol(pol_q), .a(drv_a), .b(drv_b), .c(drv_c), .d(drv_d)
);

// File: tb/test_fine_pwm_ctrl.sv
module test_fine_pwm_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_req = 1'b0;
  logic [12:0] cw = '0;
  logic [7:0]  fw = '0;
  logic [1:0]  ow = '0;
  logic        mw = 1'b0;
  logic        pw = 1'b0;
  logic        ret_s = 1'b0;
  logic        ret_x = 1'b0;
  logic        dly_trig, drv_a, drv_b, drv_c, drv_d;
  logic [7:0]  fine_code;

  int n_run = 0, n_fail = 0, stub_cnt = 0;
  bit done = 0;

  // mid-period write
  bit          mid_en = 0;
  logic [12:0] m_cw; logic [7:0] m_fw; logic [1:0] m_ow; logic m_mw, m_pw;

  // per-window results
  int r_a, r_b, r_c, r_d, r_t, r_tidx, r_ofirst;
  logic [7:0] r_fc;
  logic a_tr [0:9000];

  always #2 clk = ~clk;

  fine_pwm_ctrl i_fine_pwm_ctrl (
    .clk(clk), .rst(rst), .start_req(start_req), .coarse_width(cw),
    .fine_width(fw), .offset_sel(ow), .mode_bipolar(mw), .polarity(pw),
    .dly_ret(ret_s | ret_x), .dly_trig(dly_trig), .fine_code(fine_code),
    .drv_a(drv_a), .drv_b(drv_b), .drv_c(drv_c), .drv_d(drv_d)
  );

  // Behavioural delay element: answers after 2 + fine[1:0] clocks.
  always @(negedge clk) begin
    if (stub_cnt > 0) begin
      stub_cnt = stub_cnt - 1;
      ret_s = (stub_cnt == 0);
    end else ret_s = 1'b0;
    if (dly_trig) stub_cnt = 2 + int'(fine_code[1:0]);
  end

  function automatic int lat(input logic [7:0] f);
    return 2 + int'(f[1:0]);
  endfunction
  function automatic int stage(input logic [1:0] o);
    return 2 * int'(o) + 1;
  endfunction
  function automatic int exp_w(input int c, input logic [7:0] f, input logic [1:0] o);
    int w;
    w = c + lat(f) + 2 - stage(o);
    return (w < 0) ? 0 : w;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_window(input int len);
    r_a = 0; r_b = 0; r_c = 0; r_d = 0; r_t = 0; r_tidx = -1; r_ofirst = -1; r_fc = '0;
    @(negedge clk);
    start_req = 1'b1;
    for (int i = 1; i <= len; i++) begin
      @(negedge clk);
      if (i == 4) start_req = 1'b0;
      if (i == 6) begin
        r_fc = fine_code;
        if (mid_en) begin
          cw = m_cw; fw = m_fw; ow = m_ow; mw = m_mw; pw = m_pw;
        end
      end
      a_tr[i] = drv_a;
      if (drv_a) r_a++;
      if (drv_b) r_b++;
      if (drv_c) r_c++;
      if (drv_d) r_d++;
      if ((drv_a | drv_b | drv_c | drv_d) && r_ofirst < 0) r_ofirst = i;
      if (dly_trig) begin
        r_t++;
        if (r_tidx < 0) r_tidx = i;
      end
    end
  endtask

  task automatic check_window(input int c, input logic [7:0] f, input logic [1:0] o,
                              input logic m, input logic p);
    int w;
    w = exp_w(c, f, o);
    chk(r_t == 1, "R1 one trigger per request", r_t, 1);
    chk(r_tidx == 4 + c, "R2 trigger timing", r_tidx, 4 + c);
    chk(r_fc == f, "R3 fine code", int'(r_fc), int'(f));
    if (w > 0) chk(r_ofirst == 4 + stage(o), "R4 set tap", r_ofirst, 4 + stage(o));
    if (!m) begin
      chk(r_a == w, "R5 width leg A", r_a, w);
      chk(r_b + r_c + r_d == 0, "R9 single-ended idle legs", r_b + r_c + r_d, 0);
    end else if (!p) begin
      chk(r_a == w && r_d == w, "R9 diagonal AD width", r_a + r_d, 2 * w);
      chk(r_b + r_c == 0, "R9 diagonal BC idle", r_b + r_c, 0);
    end else begin
      chk(r_b == w && r_c == w, "R9 diagonal BC width", r_b + r_c, 2 * w);
      chk(r_a + r_d == 0, "R9 diagonal AD idle", r_a + r_d, 0);
    end
  endtask

  task automatic period(input int c, input logic [7:0] f, input logic [1:0] o,
                        input logic m, input logic p);
    cw = 13'(c); fw = f; ow = o; mw = m; pw = p;
    run_window(c + lat(f) + 24);
    check_window(c, f, o, m, p);
  endtask

  initial begin
    int cc, ll;
    logic [7:0] ff; logic [1:0] oo;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    // R10 reset state
    chk({drv_a, drv_b, drv_c, drv_d, dly_trig} == 5'b0, "R10 legs low in reset",
        int'({drv_a, drv_b, drv_c, drv_d, dly_trig}), 0);
    chk(fine_code == 8'd0, "R10 fine code cleared", int'(fine_code), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    period(3, 8'h00, 2'd0, 1'b0, 1'b0);
    period(0, 8'h00, 2'd1, 1'b0, 1'b0);   // R5 width one
    period(1, 8'h00, 2'd2, 1'b0, 1'b0);   // R5 clear beats set: width zero
    chk(r_a == 0, "R5 zero width", r_a, 0);
    period(7, 8'h5a, 2'd3, 1'b1, 1'b0);
    period(4, 8'hc3, 2'd0, 1'b1, 1'b1);
    period(8191, 8'h03, 2'd3, 1'b0, 1'b0); // R2 largest coarse value

    // R8 mid-period write is deferred
    m_cw = 13'd9; m_fw = 8'h02; m_ow = 2'd1; m_mw = 1'b1; m_pw = 1'b1;
    mid_en = 1;
    cw = 13'd2; fw = 8'h01; ow = 2'd0; mw = 1'b0; pw = 1'b0;
    run_window(40);
    mid_en = 0;
    check_window(2, 8'h01, 2'd0, 1'b0, 1'b0);
    chk(r_a == exp_w(2, 8'h01, 2'd0), "R8 old values hold", r_a, exp_w(2, 8'h01, 2'd0));
    run_window(40);
    check_window(9, 8'h02, 2'd1, 1'b1, 1'b1);
    chk(r_b == exp_w(9, 8'h02, 2'd1), "R8 new values next period", r_b, exp_w(9, 8'h02, 2'd1));

    // R6 stray returned edge while idle
    mw = 1'b0; pw = 1'b0;
    repeat (3) @(negedge clk);
    ret_x = 1'b1;
    @(negedge clk);
    ret_x = 1'b0;
    begin
      int hits = 0;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (drv_a | drv_b | drv_c | drv_d | dly_trig) hits++;
      end
      chk(hits == 0, "R6 stray edge ignored", hits, 0);
    end
    period(5, 8'h02, 2'd1, 1'b0, 1'b0);

    // R7 start during an active pulse
    cw = 13'd60; fw = 8'h00; ow = 2'd0; mw = 1'b0; pw = 1'b0;
    run_window(20);
    chk(r_a == 16, "R7 first pulse running to window end", r_a, 16);
    cw = 13'd5;
    run_window(40);
    chk(a_tr[3] == 1'b1, "R7 pulse still high before new start", int'(a_tr[3]), 1);
    chk(a_tr[4] == 1'b0, "R7 pulse cut by new start", int'(a_tr[4]), 0);
    chk(r_t == 1 && r_tidx == 9, "R7 counter reloaded", r_tidx, 9);

    // R10 reset during a pulse
    cw = 13'd30; fw = 8'h00; ow = 2'd0;
    @(negedge clk);
    start_req = 1'b1;
    repeat (4) @(negedge clk);
    start_req = 1'b0;
    repeat (6) @(negedge clk);
    chk(drv_a == 1'b1, "R10 pulse active before reset", int'(drv_a), 1);
    rst = 1'b1;
    @(negedge clk);
    chk({drv_a, drv_b, drv_c, drv_d} == 4'b0, "R10 legs cleared by reset",
        int'({drv_a, drv_b, drv_c, drv_d}), 0);
    @(negedge clk);
    rst = 1'b0;
    begin
      int hits = 0;
      for (int i = 0; i < 50; i++) begin
        @(negedge clk);
        if (dly_trig | drv_a) hits++;
      end
      chk(hits == 0, "R10 counter stopped by reset", hits, 0);
    end

    // Constrained random periods
    for (int k = 0; k < 40; k++) begin
      cc = int'($urandom_range(0, 60));
      ff = 8'($urandom);
      oo = 2'($urandom);
      ll = lat(ff);
      if (cc + ll + 2 < stage(oo)) cc = stage(oo);
      period(cc, ff, oo, 1'($urandom), 1'($urandom));
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule